// File: doc/BRIEF.md
# Vector Register Group Operand Checker

This unit sits in the decode stage of a small vector core. For one operand at a time it takes the configured element width and register grouping, the operand's role, and a 5-bit register specifier. It works out the width and grouping that the operand actually uses. An operand may be a plain operand, the destination of a widening operation, or the source of a narrowing operation. From these it marks which physical registers the operand's group covers.

It raises an illegal flag for encodings that cannot be honoured: a group that does not start on its alignment boundary, a grouping above eight registers, an element wider than 64 bits, or an unused role code. A fixed-ratio mode accepts only configurations in which element width and grouping scale together, so the element count of a group never changes. The unit also reports that element count, the maximum vector length. Each result appears one clock after its request.

Top module: `vgroup_chk`

## Requirements
- R1: A request with `in_valid` high is answered with `out_valid` high exactly one clock edge later; a cycle without a request gives `out_valid` low after the next edge. A synchronous reset drives `out_valid` low.
- R2: Width code 0..3 means 8, 16, 32 or 64 bits, and grouping code 0..3 means 1, 2, 4 or 8 registers. For role 0 (plain), `eff_w_log2` equals the width code and `eff_grp_log2` equals the grouping code. Both outputs are log2 values, the width counted in units of 8 bits.
- R3: For role 1 (widening destination) and role 2 (narrowing source), the effective width and the effective grouping are both one step above the configured values.
- R4: An effective grouping above 8 registers raises `illegal`.
- R5: An effective element width above 64 bits raises `illegal`.
- R6: A specifier that is not a multiple of the effective group size raises `illegal`.
- R7: Role code 3 raises `illegal`.
- R8: With `fixed_ratio` high, any pair other than width code equal to grouping code (8/1, 16/2, 32/4, 64/8) raises both `cfg_illegal` and `illegal`. With `fixed_ratio` low, `cfg_illegal` stays low.
- R9: `max_len` equals VLEN times the configured group size, divided by the configured element width in bits (VLEN = 64 by default).
- R10: When legal, `grp_mask` has bit r set exactly for spec <= r < spec + group size. When `illegal` is high, `grp_mask` is all zeros.
- R11: For every legal result, effective width over effective grouping equals the configured ratio.
- R12: In fixed-ratio mode, plain operands have 32, 16, 8 and 4 legal specifiers for 8, 16, 32 and 64-bit elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| fixed_ratio | input | 1 | Accept only width/grouping pairs with a constant element count |
| elem_w_code | input | 2 | Configured element width code (8,16,32,64) |
| grp_code | input | 2 | Configured grouping code (1,2,4,8) |
| role | input | 2 | 0 plain, 1 widening destination, 2 narrowing source, 3 unused |
| reg_spec | input | 5 | Lowest register of the group |
| out_valid | output | 1 | Result present |
| eff_w_log2 | output | 3 | log2(effective width / 8) |
| eff_grp_log2 | output | 3 | log2(effective group size) |
| grp_mask | output | 32 | Physical registers covered by the group |
| max_len | output | 7 | Maximum vector length for the configuration |
| illegal | output | 1 | Reserved or unsupported operand encoding |
| cfg_illegal | output | 1 | Configuration rejected in fixed-ratio mode |

## Verification
The assertions assume that every field is known whenever `in_valid` is high. They also assume the request fields stay steady from the falling edge to the next rising edge. The stimulus sets all fields together at falling edges, one request per cycle. It sweeps every combination of mode, width, grouping, role and specifier, so the unused role code and the reserved specifiers are all applied. Idle cycles between requests exercise the valid path.

// File: rtl/vgc_pkg.sv
package vgc_pkg;

  typedef enum logic [1:0] {
    ROLE_PLAIN      = 2'd0,
    ROLE_WIDE_DST   = 2'd1,
    ROLE_NARROW_SRC = 2'd2,
    ROLE_UNUSED     = 2'd3
  } vgc_role_e;

  // Largest legal log2 values: 64-bit elements, eight-register groups.
  localparam int unsigned MAX_W_LOG2   = 3;
  localparam int unsigned MAX_GRP_LOG2 = 3;

  typedef struct packed {
    logic [2:0] w_log2;
    logic [2:0] grp_log2;
    logic       width_over;
    logic       group_over;
    logic       role_bad;
  } vgc_eff_t;

  // Widening destinations and narrowing sources take one log2 step up.
  function automatic logic steps_up(input vgc_role_e r);
    return (r == ROLE_WIDE_DST) || (r == ROLE_NARROW_SRC);
  endfunction

  function automatic vgc_eff_t derive_eff(input logic [1:0] w_code,
                                          input logic [1:0] g_code,
                                          input vgc_role_e  r);
    vgc_eff_t e;
    logic [2:0] step;
    step         = {2'b00, steps_up(r)};
    e.w_log2     = {1'b0, w_code} + step;
    e.grp_log2   = {1'b0, g_code} + step;
    e.width_over = e.w_log2 > 3'(MAX_W_LOG2);
    e.group_over = e.grp_log2 > 3'(MAX_GRP_LOG2);
    e.role_bad   = (r == ROLE_UNUSED);
    return e;
  endfunction

endpackage

// File: rtl/vgc_effective.sv
module vgc_effective
  import vgc_pkg::*;
(
  input  logic [1:0] w_code,
  input  logic [1:0] g_code,
  input  logic [1:0] role_raw,
  output vgc_eff_t   eff
);
  vgc_role_e role_e;

  always_comb begin
    role_e = vgc_role_e'(role_raw);
    eff    = derive_eff(w_code, g_code, role_e);
  end
endmodule

// File: rtl/vgc_legality.sv
module vgc_legality
  import vgc_pkg::*;
#(
  parameter int unsigned SPEC_W = 5
) (
  input  logic [SPEC_W-1:0] spec,
  input  vgc_eff_t          eff,
  input  logic              fixed_ratio,
  input  logic [1:0]        w_code,
  input  logic [1:0]        g_code,
  output logic              misaligned,
  output logic              cfg_bad,
  output logic              illegal
);
  localparam int unsigned EW = SPEC_W + 2;

  logic [EW-1:0] grp_size;
  logic [EW-1:0] spec_ext;

  always_comb begin
    grp_size   = EW'(1) << eff.grp_log2;
    spec_ext   = EW'(spec);
    misaligned = |(spec_ext & (grp_size - EW'(1)));
    cfg_bad    = fixed_ratio && (w_code != g_code);
    illegal    = eff.role_bad | eff.width_over | eff.group_over |
                 misaligned | cfg_bad;
  end
endmodule

// File: rtl/vgc_group_mask.sv
module vgc_group_mask #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned SPEC_W = 5
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic [2:0]        grp_log2,
  input  logic              enable,
  output logic [NREG-1:0]   mask
);
  localparam int unsigned EW = SPEC_W + 2;

  logic [EW-1:0] lo;
  logic [EW-1:0] hi;

  always_comb begin
    lo = EW'(spec);
    hi = lo + (EW'(1) << grp_log2);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [EW-1:0] IDX = EW'(i);
    assign mask[i] = enable && (IDX >= lo) && (IDX < hi);
  end
endmodule

// File: rtl/vgc_length.sv
module vgc_length #(
  parameter int unsigned VLEN = 64,
  parameter int unsigned LEN_W = 7
) (
  input  logic [1:0]       w_code,
  input  logic [1:0]       g_code,
  output logic [LEN_W-1:0] max_len
);
  localparam int unsigned PW = LEN_W + 4;

  logic [PW-1:0] scaled;
  logic [2:0]    shamt;

  always_comb begin
    scaled  = PW'(VLEN) << g_code;
    shamt   = {1'b0, w_code} + 3'd3;
    max_len = LEN_W'(scaled >> shamt);
  end
endmodule

// File: rtl/vgroup_chk.sv
module vgroup_chk
  import vgc_pkg::*;
#(
  parameter int unsigned VLEN   = 64,
  parameter int unsigned NREG   = 32,
  parameter int unsigned SPEC_W = $clog2(NREG),
  parameter int unsigned LEN_W  = $clog2(VLEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              fixed_ratio,
  input  logic [1:0]        elem_w_code,
  input  logic [1:0]        grp_code,
  input  logic [1:0]        role,
  input  logic [SPEC_W-1:0] reg_spec,
  output logic              out_valid,
  output logic [2:0]        eff_w_log2,
  output logic [2:0]        eff_grp_log2,
  output logic [NREG-1:0]   grp_mask,
  output logic [LEN_W-1:0]  max_len,
  output logic              illegal,
  output logic              cfg_illegal
);
  vgc_eff_t         eff_c;
  logic             misaligned_c;
  logic             cfg_bad_c;
  logic             illegal_c;
  logic [NREG-1:0]  mask_c;
  logic [LEN_W-1:0] len_c;

  vgc_effective u_eff (
    .w_code   (elem_w_code),
    .g_code   (grp_code),
    .role_raw (role),
    .eff      (eff_c)
  );

  vgc_legality #(.SPEC_W(SPEC_W)) u_legal (
    .spec        (reg_spec),
    .eff         (eff_c),
    .fixed_ratio (fixed_ratio),
    .w_code      (elem_w_code),
    .g_code      (grp_code),
    .misaligned  (misaligned_c),
    .cfg_bad     (cfg_bad_c),
    .illegal     (illegal_c)
  );

  vgc_group_mask #(.NREG(NREG), .SPEC_W(SPEC_W)) u_mask (
    .spec     (reg_spec),
    .grp_log2 (eff_c.grp_log2),
    .enable   (!illegal_c),
    .mask     (mask_c)
  );

  vgc_length #(.VLEN(VLEN), .LEN_W(LEN_W)) u_len (
    .w_code  (elem_w_code),
    .g_code  (grp_code),
    .max_len (len_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      eff_w_log2   <= '0;
      eff_grp_log2 <= '0;
      grp_mask     <= '0;
      max_len      <= '0;
      illegal      <= 1'b0;
      cfg_illegal  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_w_log2   <= eff_c.w_log2;
        eff_grp_log2 <= eff_c.grp_log2;
        grp_mask     <= mask_c;
        max_len      <= len_c;
        illegal      <= illegal_c;
        cfg_illegal  <= cfg_bad_c;
      end
    end
  end

  // Checks on the registered result against the request one edge earlier.
  AST_VALID_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_GROUP_CEILING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> (eff_grp_log2 <= 3'd3)); // R4
  AST_WIDTH_CEILING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> (eff_w_log2 <= 3'd3)); // R5
  AST_CFG_FORCES_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_illegal) |-> illegal); // R8
  AST_MASK_CLEAR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (grp_mask == '0)); // R10
  AST_MASK_POPULATION: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |->
      ($countones(grp_mask) == (32'd1 << eff_grp_log2))); // R10
  AST_MASK_BASE_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !illegal_c) |=> grp_mask[$past(reg_spec)]); // R10
  AST_RATIO_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !illegal_c) |=>
      ((eff_w_log2 - eff_grp_log2) ==
       ({1'b0, $past(elem_w_code)} - {1'b0, $past(grp_code)}))); // R11
  AST_FIXED_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_ratio && !cfg_bad_c) |=>
      (max_len == LEN_W'(VLEN / 8))); // R9
endmodule

// File: tb/test_vgroup_chk.sv
module test_vgroup_chk;
  localparam int VLEN = 64;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       fixed_ratio;
  logic [1:0] elem_w_code;
  logic [1:0] grp_code;
  logic [1:0] role;
  logic [4:0] reg_spec;
  logic       out_valid;
  logic [2:0] eff_w_log2;
  logic [2:0] eff_grp_log2;
  logic [31:0] grp_mask;
  logic [6:0] max_len;
  logic       illegal;
  logic       cfg_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int legal_count [4];

  always #2 clk = ~clk;

  vgroup_chk i_vgroup_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fixed_ratio(fixed_ratio),
    .elem_w_code(elem_w_code), .grp_code(grp_code), .role(role),
    .reg_spec(reg_spec), .out_valid(out_valid), .eff_w_log2(eff_w_log2),
    .eff_grp_log2(eff_grp_log2), .grp_mask(grp_mask), .max_len(max_len),
    .illegal(illegal), .cfg_illegal(cfg_illegal)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (fr=%0d w=%0d g=%0d role=%0d spec=%0d)",
               req, act, exp, fixed_ratio, elem_w_code, grp_code, role, reg_spec);
    end
  endtask

  task automatic apply(input int fr, input int w, input int g, input int r, input int s);
    int bits, regs, exp_bits, exp_regs;
    bit bad_cfg, bad;
    logic [31:0] exp_mask;
    fixed_ratio = fr[0]; elem_w_code = w[1:0]; grp_code = g[1:0];
    role = r[1:0]; reg_spec = s[4:0]; in_valid = 1'b1;
    @(negedge clk);
    bits = 8 * (1 << w);
    regs = 1 << g;
    exp_bits = (r == 1 || r == 2) ? bits * 2 : bits;
    exp_regs = (r == 1 || r == 2) ? regs * 2 : regs;
    bad_cfg = (fr != 0) && (bits / regs != 8);
    bad = (r == 3) || (exp_bits > 64) || (exp_regs > 8) ||
          (s % exp_regs != 0) || bad_cfg;
    exp_mask = '0;
    for (int k = 0; k < 32; k++)
      if (!bad && k >= s && k < s + exp_regs) exp_mask[k] = 1'b1;
    check("R1 valid", out_valid, 1);
    check("R8 cfg_illegal", cfg_illegal, bad_cfg);
    if (r == 3) check("R7 illegal", illegal, 1);
    else if (exp_regs > 8) check("R4 illegal", illegal, 1);
    else if (exp_bits > 64) check("R5 illegal", illegal, 1);
    else if (s % exp_regs != 0) check("R6 illegal", illegal, 1);
    else check("R8 illegal", illegal, bad_cfg);
    check("R10 mask", grp_mask, exp_mask);
    check("R9 max_len", max_len, VLEN * regs / bits);
    if (!bad) begin
      if (r == 0) begin
        check("R2 width", 8 << eff_w_log2, exp_bits);
        check("R2 group", 1 << eff_grp_log2, exp_regs);
      end else begin
        check("R3 width", 8 << eff_w_log2, exp_bits);
        check("R3 group", 1 << eff_grp_log2, exp_regs);
      end
      check("R11 ratio", (8 << eff_w_log2) * regs, bits * (1 << eff_grp_log2));
      if (fr != 0 && r == 0) legal_count[w]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; fixed_ratio = 1'b0;
    elem_w_code = '0; grp_code = '0; role = '0; reg_spec = '0;
    for (int i = 0; i < 4; i++) legal_count[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R10 reset mask", grp_mask, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle out_valid", out_valid, 0);
    for (int fr = 0; fr < 2; fr++)
      for (int w = 0; w < 4; w++)
        for (int g = 0; g < 4; g++)
          for (int r = 0; r < 4; r++)
            for (int s = 0; s < 32; s++)
              apply(fr, w, g, r, s);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 gap out_valid", out_valid, 0);
    for (int w = 0; w < 4; w++)
      check("R12 legal specifiers", legal_count[w], 32 >> w);
    apply(1, 2, 2, 0, 8);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears valid", out_valid, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule